// File: doc/BRIEF.md
# Descriptor-Driven Multi-Channel DMA Engine

This block is a byte-wide DMA engine with a parameterised number of channels (five by default). Channel settings are not held in per-channel configuration registers. Software places an 8-byte descriptor anywhere in the 16-bit address space, writes the descriptor's address into the channel's base pointer, and arms the channel. The engine then reads the descriptor through its own memory master port and keeps the decoded copy as the channel's working context.

Once a channel is armed, a trigger makes it move bytes from a source address to a destination address. The trigger is either an external event line picked by the descriptor or a software trigger write. Each address can stay fixed, step by +1 or +2, or step by -1. This covers the common case of draining one peripheral data register into an incrementing buffer, and the reverse.

One shared sequencer serves every channel. Descriptor fetches come ahead of transfers. Among the channels waiting to transfer, a priority arbiter picks the next one for every single byte. When a channel's count runs out, the channel disarms and sets its own completion flag, and software clears that flag by writing 1 to it.

Top module: `dma_engine`

## Requirements
- R1: After reset no memory request is issued, every completion flag is 0, `irq` is 0 and no channel is armed.
- R2: Writing a 1 to bit n at control address 8 makes channel n read 8 bytes at base, base+1 … base+7, in that order. The base is set by writing control address n. The descriptor bytes are: 0–1 source address (low byte first), 2–3 destination address, 4 count[7:0], 5 bits 4:0 count[12:8], 6 bits 4:0 trigger number and bit 5 mode (0 single, 1 block), 7 bits 1:0 source step, 3:2 destination step, 5:4 priority. After the fetch the channel is armed.
- R3: In single mode each trigger moves exactly one byte: one read of the source, then one write of that byte to the destination. The channel stays armed while count remains.
- R4: In block mode one trigger moves the whole count, one byte after another.
- R5: Step codes are 0 fixed, 1 +1, 2 +2, 3 −1. They are applied after each byte, with 16-bit wrap-around.
- R6: Trigger number t in 1..31 fires the channel when `trig_in[t]` is high during a cycle. Trigger number 0 means software only. Writing a 1 to bit n at control address 10 fires channel n whatever its trigger number. Triggers on other lines, or on a channel that is not armed, cause no transfer.
- R7: Among channels waiting to transfer, the numerically highest priority goes first, and equal priorities go to the lower channel number. The choice is made again before every byte.
- R8: When the count reaches zero the channel disarms, sets `irq_flags[n]`, and `irq` goes high.
- R9: Writing control address 9 clears the flags whose data bits are 1. Bits that are 0 leave their flags unchanged.
- R10: A descriptor with count 0 makes no transfer. It sets the completion flag as soon as the fetch ends and leaves the channel unarmed.
- R11: A memory request keeps its address, direction and write data unchanged until `mem_gnt` is seen. Read data is taken in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 4 | Control address: 0..NUM_CH-1 base pointers, 8 arm, 9 flag clear, 10 software trigger |
| cfg_wdata | input | 16 | Control write data |
| trig_in | input | 32 | External event lines, one cycle high per event |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | Grant; completes the access in this cycle |
| mem_rdata | input | 8 | Read data, valid in the grant cycle |
| irq_flags | output | NUM_CH | Per-channel completion flags |
| irq | output | 1 | OR of all completion flags |
| ch_armed | output | NUM_CH | Channel armed state |

## Verification
A channel becomes armed one cycle after the grant of its eighth descriptor read. The first byte of a transfer needs at least three cycles after the trigger edge: one for arbitration, one for the read and one for the write, each longer by any grant stall. A completion flag changes on the same edge that grants the final write. Because grants are stalled in a fixed pattern, the bench never waits for a fixed cycle number. Expected writes go into a queue, and a monitor compares each granted write, in order, at the falling edge. Flag and armed checks happen only after the queue has drained and three more cycles have passed. Checks for "nothing happens" count writes over a 20-cycle window.

// File: rtl/dma_pkg.sv
// Package: shared descriptor type, step encoding and helpers for the DMA engine.
// Assumes a 16-bit byte address space and an 8-byte descriptor.
package dma_pkg;
    localparam int ADDR_W     = 16;
    localparam int LEN_W      = 13;
    localparam int TRIG_SEL_W = 5;
    localparam int TRIG_W     = 1 << TRIG_SEL_W;
    localparam int PRIO_W     = 2;
    localparam int DESC_BYTES = 8;
    localparam int DESC_BITS  = DESC_BYTES * 8;
    localparam int FIDX_W     = $clog2(DESC_BYTES);

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC1 = 2'd1,
        STEP_INC2 = 2'd2,
        STEP_DEC1 = 2'd3
    } step_e;

    typedef struct packed {
        logic [ADDR_W-1:0]     src;
        logic [ADDR_W-1:0]     dst;
        logic [LEN_W-1:0]      len;
        logic [TRIG_SEL_W-1:0] trig;
        logic                  blk;
        step_e                 sstep;
        step_e                 dstep;
        logic [PRIO_W-1:0]     prio;
    } desc_t;

    // Next address after one byte for a given step code (wraps at 16 bits).
    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a, input step_e s);
        case (s)
            STEP_NONE: step_addr = a;
            STEP_INC1: step_addr = a + ADDR_W'(1);
            STEP_INC2: step_addr = a + ADDR_W'(2);
            default:   step_addr = a - ADDR_W'(1);
        endcase
    endfunction

    // Decode the raw descriptor image; byte k sits at raw[8k+7:8k].
    function automatic desc_t unpack_desc(input logic [DESC_BITS-1:0] raw);
        desc_t d;
        d.src   = raw[15:0];
        d.dst   = raw[31:16];
        d.len   = {raw[44:40], raw[39:32]};
        d.trig  = raw[52:48];
        d.blk   = raw[53];
        d.sstep = step_e'(raw[57:56]);
        d.dstep = step_e'(raw[59:58]);
        d.prio  = raw[61:60];
        return d;
    endfunction
endpackage

// File: rtl/dma_regs.sv
// Control register file: base pointers, arm and software-trigger strobes,
// completion flags with write-1-to-clear. Assumes NUM_CH <= 8.
module dma_regs
    import dma_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CA_W   = 4,
    parameter int CD_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CA_W-1:0]              cfg_addr,
    input  logic [CD_W-1:0]              cfg_wdata,
    input  logic [NUM_CH-1:0]            done_vec,
    output logic [NUM_CH-1:0][ADDR_W-1:0] base_ptr,
    output logic [NUM_CH-1:0]            arm_vec,
    output logic [NUM_CH-1:0]            swtrig_vec,
    output logic [NUM_CH-1:0]            irq_flags
);
    localparam logic [CA_W-1:0] A_ARM = CA_W'(8);
    localparam logic [CA_W-1:0] A_CLR = CA_W'(9);
    localparam logic [CA_W-1:0] A_SWT = CA_W'(10);

    logic [NUM_CH-1:0] clr_vec;

    // Decode the one-cycle strobes for arm, clear and software trigger.
    always_comb begin
        arm_vec    = (cfg_we && cfg_addr == A_ARM) ? cfg_wdata[NUM_CH-1:0] : '0;
        clr_vec    = (cfg_we && cfg_addr == A_CLR) ? cfg_wdata[NUM_CH-1:0] : '0;
        swtrig_vec = (cfg_we && cfg_addr == A_SWT) ? cfg_wdata[NUM_CH-1:0] : '0;
    end

    // Hold the per-channel descriptor base pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_ptr <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (cfg_we && cfg_addr == CA_W'(i)) base_ptr[i] <= cfg_wdata[ADDR_W-1:0];
            end
        end
    end

    // Completion flags: a new completion wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_flags <= '0;
        else        irq_flags <= (irq_flags & ~clr_vec) | done_vec;
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_flag_chk
            // R8: a flag rises only after its channel reported completion
            a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_flags[i]) |-> $past(done_vec[i]));
            // R9: writing 1 clears a flag unless a completion arrives at once
            a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_addr == A_CLR && cfg_wdata[i] && !done_vec[i]) |=> !irq_flags[i]);
        end
    endgenerate
endmodule

// File: rtl/dma_channel.sv
// One channel's context: the fetched descriptor, armed state, pending fetch
// and pending trigger. The sequencer loads it after a fetch and writes back
// the stepped addresses and count after every byte.
module dma_channel
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_req,
    input  logic              sw_trig,
    input  logic [TRIG_W-1:0] trig_in,
    input  logic              ld_en,
    input  desc_t             ld_desc,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_src,
    input  logic [ADDR_W-1:0] wb_dst,
    input  logic [LEN_W-1:0]  wb_len,
    output desc_t             ctx,
    output logic              armed,
    output logic              fetch_pend,
    output logic              xfer_pend
);
    logic trig_pend;
    logic trig_hit;

    // A trigger counts only while armed; trigger number 0 is software only.
    always_comb begin
        trig_hit  = armed && (sw_trig || (ctx.trig != '0 && trig_in[ctx.trig]));
        xfer_pend = armed && trig_pend && !fetch_pend;
    end

    // Track fetch requests, context, armed state and latched triggers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx        <= '0;
            armed      <= 1'b0;
            fetch_pend <= 1'b0;
            trig_pend  <= 1'b0;
        end else begin
            if (arm_req)    fetch_pend <= 1'b1;
            else if (ld_en) fetch_pend <= 1'b0;

            if (ld_en) begin
                ctx       <= ld_desc;
                armed     <= (ld_desc.len != '0);
                trig_pend <= 1'b0;
            end else if (wb_en) begin
                ctx.src <= wb_src;
                ctx.dst <= wb_dst;
                ctx.len <= wb_len;
                if (wb_len == '0) begin
                    armed     <= 1'b0;
                    trig_pend <= 1'b0;
                end else if (trig_hit) begin
                    trig_pend <= 1'b1;
                end else if (!ctx.blk) begin
                    trig_pend <= 1'b0;
                end
            end else if (trig_hit) begin
                trig_pend <= 1'b1;
            end
        end
    end

    // R8: the last byte disarms the channel
    a_r8_disarm_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_len == '0 && !ld_en) |=> !armed);
    // R10: an empty descriptor never arms the channel
    a_r10_zero_not_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_desc.len == '0) |=> !armed);
endmodule

// File: rtl/dma_arbiter.sv
// Priority picker: the highest priority value among the requesters wins, and
// ties go to the lowest index. Purely combinational; the clock is for checks.
module dma_arbiter
    import dma_pkg::*;
#(
    parameter int NUM_CH = 5,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             req,
    input  logic [NUM_CH-1:0][PRIO_W-1:0] prio,
    output logic                          gnt_valid,
    output logic [IDX_W-1:0]              gnt_idx
);
    logic [PRIO_W-1:0] best;

    // Scan upward; only a strictly higher priority replaces the current pick.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        best      = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && (!gnt_valid || prio[i] > best)) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(i);
                best      = prio[i];
            end
        end
    end

    // R7: any request yields a grant to a requester
    a_r7_grant_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (gnt_valid && req[gnt_idx]));
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_win_chk
            // R7: no requester beats the winner on priority or on index at equal priority
            a_r7_winner_order: assert property (@(posedge clk) disable iff (!rst_n)
                (req[i] && gnt_valid) |->
                ((prio[i] < prio[gnt_idx]) || (prio[i] == prio[gnt_idx] && IDX_W'(i) >= gnt_idx)));
        end
    endgenerate
endmodule

// File: rtl/dma_seq.sv
// Shared sequencer and memory master. In idle it starts a pending descriptor
// fetch (8 reads), or else one byte for the winning channel (read, then
// write). It holds each request stable until granted and takes read data in
// the grant cycle.
module dma_seq
    import dma_pkg::*;
#(
    parameter int NUM_CH = 5,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_valid,
    input  logic [IDX_W-1:0]              fetch_idx,
    input  logic                          xfer_valid,
    input  logic [IDX_W-1:0]              xfer_idx,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] base_ptr,
    input  desc_t [NUM_CH-1:0]            ctx,
    output logic [NUM_CH-1:0]             ld_en_vec,
    output desc_t                         ld_desc,
    output logic [NUM_CH-1:0]             wb_en_vec,
    output logic [ADDR_W-1:0]             wb_src,
    output logic [ADDR_W-1:0]             wb_dst,
    output logic [LEN_W-1:0]              wb_len,
    output logic [NUM_CH-1:0]             done_vec,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [7:0]                    mem_wdata,
    input  logic                          mem_gnt,
    input  logic [7:0]                    mem_rdata
);
    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_RD, S_WR} state_e;

    state_e               state;
    logic [IDX_W-1:0]     cur;
    logic [FIDX_W-1:0]    fidx;
    logic [DESC_BITS-1:0] fbuf;
    logic [ADDR_W-1:0]    w_src;
    logic [ADDR_W-1:0]    w_dst;
    logic [LEN_W-1:0]     w_len;
    step_e                w_sstep;
    step_e                w_dstep;
    logic [7:0]           w_data;
    logic                 wb_fire;
    logic [NUM_CH-1:0]    cur_onehot;

    // Drive the memory master from the current state.
    always_comb begin
        mem_req   = (state == S_FETCH) || (state == S_RD) || (state == S_WR);
        mem_we    = (state == S_WR);
        mem_addr  = (state == S_WR) ? w_dst : w_src;
        mem_wdata = w_data;
    end

    // Load, write-back and completion strobes toward the channels.
    always_comb begin
        cur_onehot = NUM_CH'(1) << cur;
        ld_desc    = unpack_desc(fbuf);
        ld_en_vec  = (state == S_LOAD) ? cur_onehot : '0;
        wb_fire    = (state == S_WR) && mem_gnt;
        wb_en_vec  = wb_fire ? cur_onehot : '0;
        wb_src     = step_addr(w_src, w_sstep);
        wb_dst     = step_addr(w_dst, w_dstep);
        wb_len     = w_len - LEN_W'(1);
        done_vec   = ((wb_fire && w_len == LEN_W'(1)) ||
                      (state == S_LOAD && ld_desc.len == '0)) ? cur_onehot : '0;
    end

    // Step the state machine; fetches come ahead of transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cur     <= '0;
            fidx    <= '0;
            fbuf    <= '0;
            w_src   <= '0;
            w_dst   <= '0;
            w_len   <= '0;
            w_sstep <= STEP_NONE;
            w_dstep <= STEP_NONE;
            w_data  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (fetch_valid) begin
                        cur   <= fetch_idx;
                        w_src <= base_ptr[fetch_idx];
                        fidx  <= '0;
                        state <= S_FETCH;
                    end else if (xfer_valid) begin
                        cur     <= xfer_idx;
                        w_src   <= ctx[xfer_idx].src;
                        w_dst   <= ctx[xfer_idx].dst;
                        w_len   <= ctx[xfer_idx].len;
                        w_sstep <= ctx[xfer_idx].sstep;
                        w_dstep <= ctx[xfer_idx].dstep;
                        state   <= S_RD;
                    end
                end
                S_FETCH: begin
                    if (mem_gnt) begin
                        fbuf  <= {mem_rdata, fbuf[DESC_BITS-1:8]};
                        w_src <= w_src + ADDR_W'(1);
                        fidx  <= fidx + FIDX_W'(1);
                        if (fidx == FIDX_W'(DESC_BYTES - 1)) state <= S_LOAD;
                    end
                end
                S_LOAD: state <= S_IDLE;
                S_RD: begin
                    if (mem_gnt) begin
                        w_data <= mem_rdata;
                        state  <= S_WR;
                    end
                end
                S_WR: begin
                    if (mem_gnt) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: an ungranted request is held unchanged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R8: at most one channel completes per cycle
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(done_vec));
endmodule

// File: rtl/dma_engine.sv
// Top of the descriptor-driven DMA engine: register file, one context per
// channel, a fetch picker (equal priorities, so the lowest channel goes
// first), a transfer priority picker and the shared sequencer.
module dma_engine
    import dma_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic [31:0]       trig_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata,
    output logic [NUM_CH-1:0] irq_flags,
    output logic              irq,
    output logic [NUM_CH-1:0] ch_armed
);
    localparam int IDX_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0][ADDR_W-1:0] base_ptr;
    logic [NUM_CH-1:0]             arm_vec, swtrig_vec, done_vec;
    logic [NUM_CH-1:0]             ld_en_vec, wb_en_vec;
    logic [NUM_CH-1:0]             fetch_pend, xfer_pend;
    logic [NUM_CH-1:0][PRIO_W-1:0] prio_vec;
    desc_t [NUM_CH-1:0]            ctx;
    desc_t                         ld_desc;
    logic [ADDR_W-1:0]             wb_src, wb_dst;
    logic [LEN_W-1:0]              wb_len;
    logic                          fetch_valid, xfer_valid;
    logic [IDX_W-1:0]              fetch_idx, xfer_idx;

    dma_regs #(.NUM_CH(NUM_CH), .CA_W(4), .CD_W(16)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .done_vec(done_vec), .base_ptr(base_ptr),
        .arm_vec(arm_vec), .swtrig_vec(swtrig_vec), .irq_flags(irq_flags)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            dma_channel ch_i (
                .clk(clk), .rst_n(rst_n), .arm_req(arm_vec[i]), .sw_trig(swtrig_vec[i]),
                .trig_in(trig_in), .ld_en(ld_en_vec[i]), .ld_desc(ld_desc),
                .wb_en(wb_en_vec[i]), .wb_src(wb_src), .wb_dst(wb_dst), .wb_len(wb_len),
                .ctx(ctx[i]), .armed(ch_armed[i]), .fetch_pend(fetch_pend[i]),
                .xfer_pend(xfer_pend[i])
            );
            assign prio_vec[i] = ctx[i].prio;
        end
    endgenerate

    dma_arbiter #(.NUM_CH(NUM_CH)) fetch_arb_i (
        .clk(clk), .rst_n(rst_n), .req(fetch_pend), .prio('0),
        .gnt_valid(fetch_valid), .gnt_idx(fetch_idx)
    );

    dma_arbiter #(.NUM_CH(NUM_CH)) xfer_arb_i (
        .clk(clk), .rst_n(rst_n), .req(xfer_pend), .prio(prio_vec),
        .gnt_valid(xfer_valid), .gnt_idx(xfer_idx)
    );

    dma_seq #(.NUM_CH(NUM_CH)) seq_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
        .xfer_valid(xfer_valid), .xfer_idx(xfer_idx), .base_ptr(base_ptr), .ctx(ctx),
        .ld_en_vec(ld_en_vec), .ld_desc(ld_desc), .wb_en_vec(wb_en_vec),
        .wb_src(wb_src), .wb_dst(wb_dst), .wb_len(wb_len), .done_vec(done_vec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    assign irq = |irq_flags;

    // R1: no request while in reset
    a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |=> !mem_req);
endmodule

// File: tb/dma_engine_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue the expected writes, a monitor compares each
// granted write in order. A 4 KB memory model grants with a fixed stall pattern.
module dma_engine_tb_top;
    localparam int NCH = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [31:0] trig_in = '0;
    logic mem_req, mem_we, mem_gnt, irq;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [NCH-1:0] irq_flags, ch_armed;

    logic [7:0] mem [4096];
    logic gnt_ok = 1'b1;
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    bit finished = 1'b0;

    logic [15:0] exp_addr[$];
    logic [7:0]  exp_data[$];
    string       exp_req[$];
    logic [15:0] rd_log[$];

    always #2.5 clk = ~clk;

    dma_engine #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .trig_in(trig_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .irq_flags(irq_flags), .irq(irq), .ch_armed(ch_armed)
    );

    assign mem_gnt   = mem_req && gnt_ok;
    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) if (mem_req && mem_we && mem_gnt) mem[mem_addr[11:0]] <= mem_wdata;

    // Stall pattern: one cycle in four is not granted.
    always @(negedge clk) begin
        cyc    <= cyc + 1;
        gnt_ok <= ((cyc % 4) != 2);
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every granted write against the queue and log reads.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_gnt) begin
            if (mem_we) begin
                wr_count++;
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R6", "unexpected write addr", int'(mem_addr), 0);
                end else begin
                    automatic logic [15:0] ea = exp_addr.pop_front();
                    automatic logic [7:0]  ed = exp_data.pop_front();
                    automatic string       er = exp_req.pop_front();
                    check(mem_addr == ea, er, "write addr", int'(mem_addr), int'(ea));
                    check(mem_wdata == ed, er, "write data", int'(mem_wdata), int'(ed));
                end
            end else begin
                rd_log.push_back(mem_addr);
            end
        end
    end

    task automatic expect_wr(input logic [15:0] a, input logic [7:0] d, input string req);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_req.push_back(req);
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_trig(input int n);
        @(negedge clk);
        trig_in[n] = 1'b1;
        @(negedge clk);
        trig_in[n] = 1'b0;
    endtask

    task automatic put_desc(input int base, input logic [15:0] src, input logic [15:0] dst,
                            input logic [12:0] len, input logic [4:0] trig, input bit blk,
                            input logic [1:0] ss, input logic [1:0] ds, input logic [1:0] pr);
        mem[base + 0] = src[7:0];
        mem[base + 1] = src[15:8];
        mem[base + 2] = dst[7:0];
        mem[base + 3] = dst[15:8];
        mem[base + 4] = len[7:0];
        mem[base + 5] = {3'b000, len[12:8]};
        mem[base + 6] = {2'b00, blk, trig};
        mem[base + 7] = {2'b00, pr, ds, ss};
    endtask

    task automatic wait_armed(input logic [NCH-1:0] mask, input string req);
        int n = 0;
        while ((ch_armed & mask) != mask && n < 300) begin @(negedge clk); n++; end
        check((ch_armed & mask) == mask, req, "armed after fetch", int'(ch_armed), int'(mask));
    endtask

    task automatic wait_drain(input string req);
        int n = 0;
        while (exp_addr.size() != 0 && n < 1000) begin @(negedge clk); n++; end
        check(exp_addr.size() == 0, req, "expected writes left", exp_addr.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int wc;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(mem_req == 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
        check(irq_flags == '0, "R1", "flags in reset", int'(irq_flags), 0);
        check(ch_armed == '0 && irq == 1'b0, "R1", "armed/irq in reset", int'(ch_armed), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NCH; i++) cfg_write(4'(i), 16'(32'h100 + 32'h10 * i));

        // R2 fetch order, R4 block transfer, R8 completion
        put_desc(32'h100, 16'h0200, 16'h0300, 13'd4, 5'd0, 1'b1, 2'd1, 2'd1, 2'd0);
        for (int k = 0; k < 4; k++) mem[32'h200 + k] = 8'(8'h10 + k);
        rd_log.delete();
        cfg_write(4'd8, 16'h0001);
        wait_armed(5'b00001, "R2");
        check(rd_log.size() == 8, "R2", "descriptor read count", rd_log.size(), 8);
        for (int k = 0; k < 8 && k < rd_log.size(); k++)
            check(rd_log[k] == 16'(32'h100 + k), "R2", "descriptor read addr", int'(rd_log[k]), 32'h100 + k);
        for (int k = 0; k < 4; k++) expect_wr(16'(32'h300 + k), 8'(8'h10 + k), "R4");
        cfg_write(4'd10, 16'h0001);
        wait_drain("R4");
        check(irq_flags[0] == 1'b1 && irq == 1'b1, "R8", "flag0 and irq", int'(irq_flags), 1);
        check(ch_armed[0] == 1'b0, "R8", "ch0 disarmed", int'(ch_armed), 0);

        // R9 write-1-to-clear
        cfg_write(4'd9, 16'h0000);
        check(irq_flags[0] == 1'b1, "R9", "flag kept on zero write", int'(irq_flags), 1);
        cfg_write(4'd9, 16'h0001);
        check(irq_flags == '0 && irq == 1'b0, "R9", "flag cleared", int'(irq_flags), 0);

        // R3 single mode with R6 external trigger 5, fixed source
        put_desc(32'h110, 16'h0210, 16'h0310, 13'd3, 5'd5, 1'b0, 2'd0, 2'd1, 2'd0);
        mem[32'h210] = 8'hA5;
        cfg_write(4'd8, 16'h0002);
        wait_armed(5'b00010, "R2");
        expect_wr(16'h0310, 8'hA5, "R3");
        pulse_trig(5);
        wait_drain("R3");
        check(ch_armed[1] == 1'b1 && irq_flags[1] == 1'b0, "R3", "armed after one unit",
              int'({ch_armed[1], irq_flags[1]}), 2);
        mem[32'h210] = 8'h5A;
        wc = wr_count;
        pulse_trig(7);
        repeat (20) @(negedge clk);
        check(wr_count == wc, "R6", "other trigger line ignored", wr_count, wc);
        expect_wr(16'h0311, 8'h5A, "R3");
        pulse_trig(5);
        wait_drain("R3");
        expect_wr(16'h0312, 8'h5A, "R3");
        pulse_trig(5);
        wait_drain("R3");
        check(irq_flags[1] == 1'b1 && ch_armed[1] == 1'b0, "R8", "ch1 done",
              int'({irq_flags[1], ch_armed[1]}), 2);
        wc = wr_count;
        pulse_trig(5);
        repeat (20) @(negedge clk);
        check(wr_count == wc, "R6", "trigger on unarmed channel ignored", wr_count, wc);
        cfg_write(4'd9, 16'h001F);

        // R5 address steps: source +2, destination -1 with wrap
        put_desc(32'h120, 16'h0220, 16'h0002, 13'd4, 5'd0, 1'b1, 2'd2, 2'd3, 2'd0);
        for (int k = 0; k < 4; k++) mem[32'h220 + 2 * k] = 8'(8'hC0 + k);
        cfg_write(4'd8, 16'h0004);
        wait_armed(5'b00100, "R2");
        expect_wr(16'h0002, 8'hC0, "R5");
        expect_wr(16'h0001, 8'hC1, "R5");
        expect_wr(16'h0000, 8'hC2, "R5");
        expect_wr(16'hFFFF, 8'hC3, "R5");
        cfg_write(4'd10, 16'h0004);
        wait_drain("R5");
        check(irq_flags[2] == 1'b1, "R5", "ch2 finished", int'(irq_flags), 4);
        cfg_write(4'd9, 16'h001F);

        // R10 zero count
        put_desc(32'h130, 16'h0230, 16'h0330, 13'd0, 5'd0, 1'b1, 2'd1, 2'd1, 2'd0);
        wc = wr_count;
        cfg_write(4'd8, 16'h0008);
        for (int n = 0; n < 100 && !irq_flags[3]; n++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(irq_flags[3] == 1'b1, "R10", "flag after empty descriptor", int'(irq_flags), 8);
        check(ch_armed[3] == 1'b0, "R10", "not armed", int'(ch_armed), 0);
        check(wr_count == wc, "R10", "no transfer", wr_count, wc);
        cfg_write(4'd9, 16'h001F);

        // R7 arbitration order across four channels fired at once
        put_desc(32'h100, 16'h0240, 16'h0340, 13'd2, 5'd0, 1'b1, 2'd1, 2'd1, 2'd1);
        put_desc(32'h110, 16'h0250, 16'h0350, 13'd2, 5'd0, 1'b1, 2'd1, 2'd1, 2'd3);
        put_desc(32'h120, 16'h0260, 16'h0360, 13'd2, 5'd0, 1'b1, 2'd1, 2'd1, 2'd3);
        put_desc(32'h140, 16'h0270, 16'h0370, 13'd1, 5'd0, 1'b0, 2'd1, 2'd1, 2'd2);
        for (int k = 0; k < 2; k++) begin
            mem[32'h240 + k] = 8'(8'h40 + k);
            mem[32'h250 + k] = 8'(8'h50 + k);
            mem[32'h260 + k] = 8'(8'h60 + k);
        end
        mem[32'h270] = 8'h70;
        cfg_write(4'd8, 16'h0017);
        wait_armed(5'b10111, "R2");
        for (int k = 0; k < 2; k++) expect_wr(16'(32'h350 + k), 8'(8'h50 + k), "R7");
        for (int k = 0; k < 2; k++) expect_wr(16'(32'h360 + k), 8'(8'h60 + k), "R7");
        expect_wr(16'h0370, 8'h70, "R7");
        for (int k = 0; k < 2; k++) expect_wr(16'(32'h340 + k), 8'(8'h40 + k), "R7");
        cfg_write(4'd10, 16'h0017);
        wait_drain("R7");
        check(irq_flags == 5'h17, "R7", "all four completed", int'(irq_flags), 32'h17);
        check(mem_req == 1'b0, "R11", "master idle at end", int'(mem_req), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule